// File: doc/BRIEF.md
# Phase-Aligned ADC Conversion Clock Generator

This block derives the conversion clock of one ADC sequencer from the system clock. Once started, it produces a clock whose period and duty follow a programmed period value. Each rising edge can be held back until a free-running phase count, shared by several sequencers, reaches a programmed value, so that all converters sample in a fixed relation to one another.

The surrounding sequencer controls it through a few inputs. A start strobe latches the configuration and begins a conversion. A stop strobe returns the clock to idle. A per-cycle stretch request lengthens the low phase ahead of a rising edge, which gives the tracking-time extension. A first-edge flag marks the edge that closes the first sample period, and that edge is never held for phase alignment. The block reports one-cycle strobes for each rising and falling edge, and a half-cycle count of the running conversion.

Top module: `adc_phase_clkgen`

## Requirements
- R1: After reset, and whenever the block is idle, adcClk, riseStrobe and fallStrobe are 0 and halfCycle is 0.
- R2: With no stretch and no phase hold, successive rising edges of adcClk are exactly P+1 system cycles apart, where P is the latched period value (P=0 behaves as P=1).
- R3: The high phase lasts floor(P/2)+1 cycles and the low phase lasts the rest of the P+1 cycles. When P+1 is odd, the high phase is therefore one cycle longer than the low phase.
- R4: A start strobe sampled at clock edge k forces adcClk low. The first rising edge follows at edge k+L, where L is the low-phase length of R3.
- R5: When the latched sync enable is 1, a rising edge that is due at edge e only happens at the first edge e' >= e at which globalPhase equals the latched phase value.
- R6: A rising edge that is due while firstEdge is 1 is never held by phase alignment.
- R7: A rising edge is not made at any edge at which stretchReq is sampled 1. adcClk stays low until the first due edge with stretchReq 0.
- R8: halfCycle is cleared by start and goes up by 1 at every rising and falling edge of adcClk. It saturates at 30.
- R9: A stop strobe sampled at an edge drives adcClk and halfCycle to 0 at that edge, and no strobe follows. Stop takes priority over a simultaneous start.
- R10: Changes to periodCfg, phaseCfg and syncEn after the start strobe have no effect on the running conversion.
- R11: riseStrobe (fallStrobe) is 1 for exactly the first system cycle in which adcClk is high (low) after an edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Start strobe: latch configuration, begin conversion |
| stopReq | input | 1 | Stop strobe: return to idle |
| periodCfg | input | 8 | Clock period in system cycles minus one |
| phaseCfg | input | 8 | Phase value that rising edges align to |
| syncEn | input | 1 | 1: align rising edges to globalPhase |
| globalPhase | input | 8 | Shared free-running phase count |
| firstEdge | input | 1 | Marks the rising edge ending the first sample period |
| stretchReq | input | 1 | Hold the pending rising edge this cycle |
| adcClk | output | 1 | Conversion clock |
| riseStrobe | output | 1 | One-cycle pulse after a rising edge |
| fallStrobe | output | 1 | One-cycle pulse after a falling edge |
| halfCycle | output | 5 | Half clock cycles since start, 0 when idle |

## Verification
The edge schedule is checked against a model for several periods: an even period for the symmetric case, an odd cycle count for the asymmetric duty, and a zero period for the smallest clock. Each schedule pins down the period, the duty split and the start latency. Sync runs with and without the first-edge flag show that the hold waits for the phase match on every edge except the marked one. A stretch window longer than the low phase shows that the edge is held by stretch alone. A long run drives the half-cycle count into saturation. A run that rewrites the configuration mid-flight shows that the latched values are kept. Stop is applied during a high phase, and stop together with start is applied while idle, to check the immediate return to idle and its priority.

// File: rtl/acg_pkg.sv
package acg_pkg;
  typedef struct packed {
    logic load;
    logic clear;
    logic rise;
    logic fall;
  } acgStrobes_t;
endpackage

// File: rtl/acg_ctrl.sv
module acg_ctrl
  import acg_pkg::*;
#(
  parameter int CFG_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             startReq,
  input  logic             stopReq,
  input  logic             firstEdge,
  input  logic             stretchReq,
  input  logic             clkLevel,
  input  logic [CFG_W-1:0] lastHigh,
  input  logic [CFG_W-1:0] lastLow,
  input  logic             phaseOk,
  output acgStrobes_t      st
);
  logic             running;
  logic [CFG_W-1:0] phaseCnt;
  logic [CFG_W-1:0] phaseLast;
  logic             riseDue;

  assign phaseLast = clkLevel ? lastHigh : lastLow;
  assign riseDue   = running && !clkLevel && (phaseCnt == lastLow);

  always_comb begin
    st = '0;
    if (stopReq) begin
      st.clear = 1'b1;
    end else if (startReq) begin
      st.load = 1'b1;
    end else if (running) begin
      // held edge: stretch always blocks, phase alignment blocks unless first edge
      st.rise = riseDue && !stretchReq && (firstEdge || phaseOk);
      st.fall = clkLevel && (phaseCnt == lastHigh);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running  <= 1'b0;
      phaseCnt <= '0;
    end else if (st.clear) begin
      running  <= 1'b0;
      phaseCnt <= '0;
    end else if (st.load) begin
      running  <= 1'b1;
      phaseCnt <= '0;
    end else if (st.rise || st.fall) begin
      phaseCnt <= '0;
    end else if (running && (phaseCnt != phaseLast)) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end
endmodule

// File: rtl/acg_datapath.sv
module acg_datapath
  import acg_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int HALF_MAX = 30,
  localparam int HALF_W  = $clog2(HALF_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  acgStrobes_t       st,
  input  logic [CFG_W-1:0]  periodCfg,
  input  logic [CFG_W-1:0]  phaseCfg,
  input  logic              syncEn,
  input  logic [CFG_W-1:0]  globalPhase,
  output logic              adcClk,
  output logic              riseStrobe,
  output logic              fallStrobe,
  output logic [HALF_W-1:0] halfCycle,
  output logic [CFG_W-1:0]  lastHigh,
  output logic [CFG_W-1:0]  lastLow,
  output logic              phaseOk
);
  logic [CFG_W-1:0] periodL;
  logic [CFG_W-1:0] phaseL;
  logic             syncL;
  logic [CFG_W-1:0] halfP;

  assign halfP    = periodL >> 1;
  assign lastHigh = halfP;
  assign lastLow  = (periodL == '0) ? '0 : (periodL - halfP - 1'b1);
  assign phaseOk  = !syncL || (globalPhase == phaseL);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      periodL <= '0;
      phaseL  <= '0;
      syncL   <= 1'b0;
    end else if (st.load) begin
      periodL <= periodCfg;
      phaseL  <= phaseCfg;
      syncL   <= syncEn;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      adcClk     <= 1'b0;
      halfCycle  <= '0;
      riseStrobe <= 1'b0;
      fallStrobe <= 1'b0;
    end else begin
      riseStrobe <= st.rise;
      fallStrobe <= st.fall;
      if (st.clear || st.load) begin
        adcClk    <= 1'b0;
        halfCycle <= '0;
      end else if (st.rise || st.fall) begin
        adcClk <= st.rise;
        if (halfCycle != HALF_W'(HALF_MAX)) halfCycle <= halfCycle + 1'b1;
      end
    end
  end
endmodule

// File: rtl/adc_phase_clkgen.sv
module adc_phase_clkgen
  import acg_pkg::*;
#(
  parameter int CFG_W    = 8,
  parameter int HALF_MAX = 30,
  localparam int HALF_W  = $clog2(HALF_MAX + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              startReq,
  input  logic              stopReq,
  input  logic [CFG_W-1:0]  periodCfg,
  input  logic [CFG_W-1:0]  phaseCfg,
  input  logic              syncEn,
  input  logic [CFG_W-1:0]  globalPhase,
  input  logic              firstEdge,
  input  logic              stretchReq,
  output logic              adcClk,
  output logic              riseStrobe,
  output logic              fallStrobe,
  output logic [HALF_W-1:0] halfCycle
);
  acgStrobes_t      st;
  logic [CFG_W-1:0] lastHigh;
  logic [CFG_W-1:0] lastLow;
  logic             phaseOk;

  acg_ctrl #(.CFG_W(CFG_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .firstEdge(firstEdge), .stretchReq(stretchReq), .clkLevel(adcClk),
    .lastHigh(lastHigh), .lastLow(lastLow), .phaseOk(phaseOk), .st(st)
  );

  acg_datapath #(.CFG_W(CFG_W), .HALF_MAX(HALF_MAX)) u_dp (
    .clk(clk), .rstN(rstN), .st(st), .periodCfg(periodCfg),
    .phaseCfg(phaseCfg), .syncEn(syncEn), .globalPhase(globalPhase),
    .adcClk(adcClk), .riseStrobe(riseStrobe), .fallStrobe(fallStrobe),
    .halfCycle(halfCycle), .lastHigh(lastHigh), .lastLow(lastLow),
    .phaseOk(phaseOk)
  );
endmodule

// File: rtl/adc_phase_clkgen_chk.sv
module adc_phase_clkgen_chk #(
  parameter int HALF_MAX = 30,
  localparam int HALF_W  = $clog2(HALF_MAX + 1)
) (
  input logic              clk,
  input logic              rstN,
  input logic              stopReq,
  input logic              adcClk,
  input logic              riseStrobe,
  input logic              fallStrobe,
  input logic [HALF_W-1:0] halfCycle
);
  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rstN)
    stopReq |=> (!adcClk && (halfCycle == '0) && !riseStrobe && !fallStrobe));

  assert_half_bound_R8: assert property (@(posedge clk) disable iff (!rstN)
    halfCycle <= HALF_W'(HALF_MAX));

  assert_half_step_R8: assert property (@(posedge clk) disable iff (!rstN)
    (riseStrobe || fallStrobe) |->
      (halfCycle == (($past(halfCycle) == HALF_W'(HALF_MAX)) ? HALF_W'(HALF_MAX)
                                                              : $past(halfCycle) + 1'b1)));

  assert_rise_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    riseStrobe |-> (adcClk && !$past(adcClk)));

  assert_fall_strobe_R11: assert property (@(posedge clk) disable iff (!rstN)
    fallStrobe |-> (!adcClk && $past(adcClk)));

  assert_rise_marked_R11: assert property (@(posedge clk) disable iff (!rstN)
    $rose(adcClk) |-> riseStrobe);
endmodule

bind adc_phase_clkgen adc_phase_clkgen_chk #(.HALF_MAX(HALF_MAX)) u_chk (
  .clk(clk), .rstN(rstN), .stopReq(stopReq), .adcClk(adcClk),
  .riseStrobe(riseStrobe), .fallStrobe(fallStrobe), .halfCycle(halfCycle)
);

// File: tb/tb_adc_phase_clkgen.sv
`timescale 1ns/1ps
module tb_adc_phase_clkgen;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       startReq = 1'b0;
  logic       stopReq = 1'b0;
  logic [7:0] periodCfg = '0;
  logic [7:0] phaseCfg = '0;
  logic       syncEn = 1'b0;
  logic [7:0] globalPhase = '0;
  logic       firstEdge = 1'b0;
  logic       stretchReq = 1'b0;
  logic       adcClk, riseStrobe, fallStrobe;
  logic [4:0] halfCycle;

  int cyc = 0;
  int nChecks = 0;
  int nFails = 0;
  bit finished = 0;

  typedef struct {
    bit    isRise;
    int    atCyc;
    int    half;
    string tag;
  } evt_t;
  evt_t expQ[$];

  adc_phase_clkgen dut (
    .clk(clk), .rstN(rstN), .startReq(startReq), .stopReq(stopReq),
    .periodCfg(periodCfg), .phaseCfg(phaseCfg), .syncEn(syncEn),
    .globalPhase(globalPhase), .firstEdge(firstEdge), .stretchReq(stretchReq),
    .adcClk(adcClk), .riseStrobe(riseStrobe), .fallStrobe(fallStrobe),
    .halfCycle(halfCycle)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  // globalPhase sampled at edge n equals n modulo 256
  initial forever begin
    @(negedge clk);
    globalPhase = 8'((cyc + 1) % 256);
  end

  task automatic check(input string tag, input int act, input int exp);
    nChecks++;
    if (act != exp) begin
      nFails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // monitor: compare every edge strobe with the scoreboard front
  initial forever begin
    @(negedge clk);
    if (rstN && (riseStrobe || fallStrobe)) begin
      if (expQ.size() == 0) begin
        nChecks++;
        nFails++;
        $display("FAIL R9: actual unexpected strobe at cycle %0d expected none", cyc);
      end else begin
        evt_t e;
        e = expQ.pop_front();
        check({e.tag, " edge kind"}, int'(riseStrobe), int'(e.isRise));
        check({e.tag, " edge cycle"}, cyc, e.atCyc);
        check({e.tag, " halfCycle R8"}, int'(halfCycle), e.half);
        check({e.tag, " clock level R11"}, int'(adcClk), int'(e.isRise));
      end
    end
  end

  // driver: compute the expected schedule, push it, then drive the stimulus
  task automatic runSeq(input string tag, input int P, input int ph, input bit sy,
                        input bit fe, input int stretchLen, input int nRises,
                        input bit changeCfg);
    int hi, lo, k, t, due, half, firstRise, lastRise;
    hi = (P >> 1) + 1;
    lo = (P == 0) ? 1 : P - (P >> 1);
    k = cyc + 1;
    t = k;
    half = 0;
    firstRise = 0;
    lastRise = 0;
    for (int i = 0; i < nRises; i++) begin
      due = t + lo;
      if (i == 0 && stretchLen > 0 && due < k + stretchLen) due = k + stretchLen;
      if (sy && !(i == 0 && fe)) while ((due % 256) != ph) due++;
      if (i == 0) firstRise = due;
      lastRise = due;
      half = (half < 30) ? half + 1 : 30;
      expQ.push_back('{1'b1, due, half, tag});
      if (i < nRises - 1) begin
        half = (half < 30) ? half + 1 : 30;
        expQ.push_back('{1'b0, due + hi, half, tag});
      end
      t = due + hi;
    end
    startReq = 1'b1;
    periodCfg = 8'(P);
    phaseCfg = 8'(ph);
    syncEn = sy;
    firstEdge = fe;
    stretchReq = (stretchLen > 0);
    while (cyc < lastRise) begin
      @(negedge clk);
      startReq = 1'b0;
      if (changeCfg) begin
        periodCfg = ~8'(P);
        phaseCfg = 8'(ph + 7);
        syncEn = 1'b1;
      end
      if (stretchLen > 0 && cyc == k + stretchLen - 1) stretchReq = 1'b0;
      if (cyc == firstRise) firstEdge = 1'b0;
    end
    // stop during the high phase after the last rise
    stopReq = 1'b1;
    @(negedge clk);
    stopReq = 1'b0;
    check({tag, " stop clears clock R9"}, int'(adcClk), 0);
    check({tag, " stop clears halfCycle R9"}, int'(halfCycle), 0);
    check({tag, " all edges seen"}, expQ.size(), 0);
    expQ.delete();
    syncEn = 1'b0;
    repeat (5) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check("R1 reset adcClk", int'(adcClk), 0);
    check("R1 reset halfCycle", int'(halfCycle), 0);
    check("R1 reset strobes", int'(riseStrobe | fallStrobe), 0);
    repeat (2) @(negedge clk);

    runSeq("R2 R4 even period", 5, 0, 0, 0, 0, 4, 0);
    runSeq("R3 odd length duty", 4, 0, 0, 0, 0, 4, 0);
    runSeq("R3 zero period", 0, 0, 0, 0, 0, 5, 0);
    runSeq("R5 phase hold", 3, 40, 1, 0, 0, 3, 0);
    runSeq("R6 first edge free", 3, 200, 1, 1, 0, 3, 0);
    runSeq("R7 stretch hold", 3, 0, 0, 0, 9, 3, 0);
    runSeq("R8 saturation", 1, 0, 0, 0, 0, 17, 0);
    runSeq("R10 latched config", 6, 0, 0, 0, 0, 4, 1);

    // stop wins over a simultaneous start
    startReq = 1'b1;
    stopReq = 1'b1;
    periodCfg = 8'd1;
    @(negedge clk);
    startReq = 1'b0;
    stopReq = 1'b0;
    repeat (10) @(negedge clk);
    check("R9 stop priority clock", int'(adcClk), 0);
    check("R9 stop priority halfCycle", int'(halfCycle), 0);
    check("R1 idle strobes", int'(riseStrobe | fallStrobe), 0);

    if (!finished) begin
      finished = 1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  end
endmodule